// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block deserialises stereo PCM audio arriving on a three-wire link: a bit clock, a framing clock that tells the two channels apart, and a serial data line. It runs entirely in the bit-clock domain. Each rising edge of the bit clock samples the framing clock and the data line. A half-frame lasts 32 bit clocks, because the bit clock runs at 64 times the sample rate. The receiver collects one 24-bit word per channel. It presents the left and right words together with a single-cycle strobe once the right word of a frame is complete.

A static two-bit format input selects the frame alignment. The choices are the standard inter-IC sound layout, a layout with the word at the start of each half-frame, and a layout with the word at the end of each half-frame. Channel polarity of the framing clock and the position of the 24-bit word within the half-frame both follow from that input. A bit position counter restarts on every framing-clock transition. As a result, a half-frame with too few or too many bit clocks damages only that half-frame.

Top module: `aud_rx`

## Requirements
- R1: While reset is high and on the first clock after it, `valid_o` is 0 and `left_o` and `right_o` are all zeros.
- R2: `fmt_i` encodes 2'b00 inter-IC sound, 2'b01 start-aligned, 2'b10 end-aligned; 2'b11 behaves exactly like 2'b00.
- R3: Inter-IC sound format: framing clock low carries the left word and high carries the right word. The MSB is sampled one bit clock after the edge where the framing clock is first seen at its new level, and the 23 following bits complete the word.
- R4: Start-aligned format: framing clock high is left and low is right. The MSB is sampled on the same edge where the new framing level is first seen.
- R5: End-aligned format: polarity as in R4. The LSB is the last bit sampled before the framing clock changes, and the MSB is sampled 8 bit clocks after the change.
- R6: Data bits outside the 24-bit window of a half-frame have no effect on any output.
- R7: `valid_o` pulses for exactly one cycle. On the edge that samples the right-channel LSB, `left_o` and `right_o` both take the new frame's words and `valid_o` rises. At all other times the outputs hold.
- R8: Bit position restarts on every framing-clock transition. An end-aligned half-frame one bit clock short yields no strobe for that frame, and the next well-formed frame is received correctly.
- R9: A completed right word produces no strobe unless a complete left word has been received since the previous strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all sampling is on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fmt_i | input | 2 | Static frame format select (see R2) |
| lrclk_i | input | 1 | Framing clock separating left and right half-frames |
| sdata_i | input | 1 | Serial data, MSB first |
| left_o | output | 24 | Last received left sample |
| right_o | output | 24 | Last received right sample |
| valid_o | output | 1 | One-cycle strobe marking a new stereo pair |

## Verification
No register sits between the data pin and the outputs' update edge. The rising edge that samples the right-channel LSB is therefore the edge on which both sample outputs and the strobe change; idle cycles and fill bits must leave them untouched. The bench drives each bit on a falling edge and computes the expected output state for the rising edge that follows. It compares strobe and both words on the next falling edge, on every clock, so any early, late or duplicated strobe shows up in the cycle it happens. The format-specific MSB delay (0, 1 or 8 bit clocks) is derived in the bench from the selected format.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

    typedef enum logic [1:0] {
        FMT_I2S = 2'b00,
        FMT_SOF = 2'b01,
        FMT_EOF = 2'b10,
        FMT_ALT = 2'b11
    } aud_fmt_e;

    // per-cycle capture control derived from bit position and format
    typedef struct packed {
        logic cap;
        logic last;
        logic is_left;
    } slot_ctl_t;

    // bit position (0 = edge where new framing level is seen) of the MSB
    function automatic int unsigned first_bit(aud_fmt_e f, int unsigned slot_w,
                                              int unsigned samp_w);
        case (f)
            FMT_SOF: return 0;
            FMT_EOF: return slot_w - samp_w;
            default: return 1;
        endcase
    endfunction

    // framing-clock level that marks the left channel
    function automatic logic left_level(aud_fmt_e f);
        return (f == FMT_SOF) || (f == FMT_EOF);
    endfunction

endpackage

// File: rtl/aud_rx_frame.sv
module aud_rx_frame #(
    parameter int SLOT_W = 32,
    localparam int IDX_W = $clog2(2 * SLOT_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lrclk_i,
    output logic             frm_edge_o,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    logic             lr_q;
    logic             primed_q;
    logic [IDX_W-1:0] cnt_q;

    always_comb begin
        frm_edge_o = primed_q && (lrclk_i != lr_q);
        if (frm_edge_o)
            idx_o = '0;
        else if (cnt_q == IDX_MAX)
            idx_o = IDX_MAX;
        else
            idx_o = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lr_q     <= 1'b0;
            primed_q <= 1'b0;
            cnt_q    <= IDX_MAX;
        end else begin
            lr_q     <= lrclk_i;
            primed_q <= 1'b1;
            cnt_q    <= idx_o;
        end
    end

endmodule

// File: rtl/aud_rx_slot.sv
module aud_rx_slot
    import aud_rx_pkg::*;
#(
    parameter int SLOT_W = 32,
    parameter int SAMP_W = 24,
    localparam int IDX_W = $clog2(2 * SLOT_W)
) (
    input  aud_fmt_e         fmt_i,
    input  logic             lrclk_i,
    input  logic [IDX_W-1:0] idx_i,
    output slot_ctl_t        ctl_o
);
    localparam logic [IDX_W-1:0] SPAN = IDX_W'(SAMP_W);

    logic [IDX_W-1:0] first;
    logic [IDX_W-1:0] rel;

    always_comb begin
        first         = IDX_W'(first_bit(fmt_i, SLOT_W, SAMP_W));
        rel           = idx_i - first;
        ctl_o.cap     = (idx_i >= first) && (rel < SPAN);
        ctl_o.last    = ctl_o.cap && (rel == SPAN - 1'b1);
        ctl_o.is_left = (lrclk_i == left_level(fmt_i));
    end

endmodule

// File: rtl/aud_rx_assemble.sv
module aud_rx_assemble
    import aud_rx_pkg::*;
#(
    parameter int SAMP_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  slot_ctl_t         ctl_i,
    input  logic              sdata_i,
    output logic [SAMP_W-1:0] left_o,
    output logic [SAMP_W-1:0] right_o,
    output logic              valid_o
);
    logic [SAMP_W-1:0] sh_q;
    logic [SAMP_W-1:0] hold_q;
    logic              lok_q;
    logic [SAMP_W-1:0] word;

    assign word = {sh_q[SAMP_W-2:0], sdata_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            hold_q  <= '0;
            lok_q   <= 1'b0;
            left_o  <= '0;
            right_o <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (ctl_i.cap)
                sh_q <= word;
            if (ctl_i.cap && ctl_i.last) begin
                if (ctl_i.is_left) begin
                    hold_q <= word;
                    lok_q  <= 1'b1;
                end else if (lok_q) begin
                    left_o  <= hold_q;
                    right_o <= word;
                    valid_o <= 1'b1;
                    lok_q   <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/aud_rx.sv
module aud_rx
    import aud_rx_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int SLOT_W   = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          fmt_i,
    input  logic                lrclk_i,
    input  logic                sdata_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o
);
    localparam int IDX_W = $clog2(2 * SLOT_W);

    logic             frm_edge;
    logic [IDX_W-1:0] idx;
    slot_ctl_t        ctl;
    aud_fmt_e         fmt;

    assign fmt = aud_fmt_e'(fmt_i);

    aud_rx_frame #(.SLOT_W(SLOT_W)) u_frame (
        .clk        (clk),
        .rst        (rst),
        .lrclk_i    (lrclk_i),
        .frm_edge_o (frm_edge),
        .idx_o      (idx)
    );

    aud_rx_slot #(.SLOT_W(SLOT_W), .SAMP_W(SAMPLE_W)) u_slot (
        .fmt_i   (fmt),
        .lrclk_i (lrclk_i),
        .idx_i   (idx),
        .ctl_o   (ctl)
    );

    aud_rx_assemble #(.SAMP_W(SAMPLE_W)) u_asm (
        .clk     (clk),
        .rst     (rst),
        .ctl_i   (ctl),
        .sdata_i (sdata_i),
        .left_o  (left_o),
        .right_o (right_o),
        .valid_o (valid_o)
    );

endmodule

// File: rtl/aud_rx_chk.sv
module aud_rx_chk #(
    parameter int SAMPLE_W = 24
) (
    input logic                clk,
    input logic                rst,
    input logic [1:0]          fmt_i,
    input logic                lrclk_i,
    input logic [SAMPLE_W-1:0] left_o,
    input logic [SAMPLE_W-1:0] right_o,
    input logic                valid_o
);
    logic rst_d;

    // R1: outputs cleared on the clock after a reset cycle
    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst_d)
            a_r1_reset_clear: assert (!valid_o && left_o == '0 && right_o == '0);
    end

    // R7: strobe lasts a single cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R7: words hold whenever no strobe is raised
    a_r7_hold_quiet: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> ($stable(left_o) && $stable(right_o)));

    // R2: strobe only follows a sample taken at the right-channel level
    a_r2_right_level: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> ($past(lrclk_i) == !($past(fmt_i) == 2'b01 || $past(fmt_i) == 2'b10)));

endmodule

bind aud_rx aud_rx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .fmt_i   (fmt_i),
    .lrclk_i (lrclk_i),
    .left_o  (left_o),
    .right_o (right_o),
    .valid_o (valid_o)
);

// File: tb/aud_rx_tb.sv
module aud_rx_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  fmt = 2'b00;
    logic        lrclk = 1'b1;
    logic        sdata = 1'b0;
    logic [23:0] left_o, right_o;
    logic        valid_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic        exp_v = 1'b0;
    logic [23:0] exp_l = '0;
    logic [23:0] exp_r = '0;
    string       exp_tag = "R1";
    int          fill_mode = 0;  // 0 random, 1 ones

    always #4 clk = ~clk;

    aud_rx u_dut (
        .clk(clk), .rst(rst), .fmt_i(fmt), .lrclk_i(lrclk), .sdata_i(sdata),
        .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
    );

    function automatic int first_of(logic [1:0] f);
        if (f == 2'b01) return 0;
        if (f == 2'b10) return 8;
        return 1;
    endfunction

    function automatic logic left_lvl(logic [1:0] f);
        return (f == 2'b01) || (f == 2'b10);
    endfunction

    task automatic compare();
        checks++;
        if (valid_o !== exp_v || left_o !== exp_l || right_o !== exp_r) begin
            errors++;
            $display("FAIL %s: valid=%b L=%h R=%h expected valid=%b L=%h R=%h",
                     exp_tag, valid_o, left_o, right_o, exp_v, exp_l, exp_r);
        end
    endtask

    // compare outputs of the previous rising edge, then drive the next bit
    task automatic step(input logic lr, input logic sd, input logic v,
                        input logic [23:0] nl, input logic [23:0] nr, input string tg);
        @(negedge clk);
        compare();
        lrclk = lr;
        sdata = sd;
        exp_v = v;
        if (v) begin
            exp_l = nl;
            exp_r = nr;
        end
        exp_tag = tg;
    endtask

    function automatic logic fill_bit();
        if (fill_mode == 1) return 1'b1;
        return 1'($urandom_range(0, 1));
    endfunction

    task automatic send_half(input logic is_left, input logic [23:0] w, input int n,
                             input logic strobe_ok, input logic [23:0] lw, input string tg);
        int f;
        logic lr;
        f  = first_of(fmt);
        lr = is_left ? left_lvl(fmt) : !left_lvl(fmt);
        for (int i = 0; i < n; i++) begin
            logic b;
            logic v;
            if (i >= f && i < f + 24) b = w[23 - (i - f)];
            else b = fill_bit();
            v = !is_left && strobe_ok && (i == f + 23);
            step(lr, b, v, lw, w, tg);
        end
    endtask

    task automatic send_frame(input logic [23:0] l, input logic [23:0] r,
                              input int nl, input int nr, input string tg);
        int f;
        logic l_ok;
        f = first_of(fmt);
        l_ok = (nl >= f + 24);
        send_half(1'b1, l, nl, 1'b0, l, tg);
        send_half(1'b0, r, nr, l_ok && (nr >= f + 24), l, tg);
    endtask

    task automatic idle(input int n, input string tg);
        for (int i = 0; i < n; i++)
            step(!left_lvl(fmt), 1'($urandom_range(0, 1)), 1'b0, '0, '0, tg);
    endtask

    task automatic restart(input logic [1:0] f);
        @(negedge clk);
        compare();
        rst   = 1'b1;
        fmt   = f;
        lrclk = !left_lvl(f);
        exp_v = 1'b0;
        exp_l = '0;
        exp_r = '0;
        exp_tag = "R1";
        idle(2, "R1");
        rst = 1'b0;
        idle(3, "R1");
    endtask

    initial begin
        void'($urandom(7));
        // R1: reset state, then R3 inter-IC sound frames
        idle(3, "R1");
        rst = 1'b0;
        idle(3, "R1");
        send_frame(24'h123456, 24'hABCDEF, 32, 32, "R3");
        send_frame(24'h800001, 24'h7FFFFE, 32, 32, "R3");
        send_frame(24'hFFFFFF, 24'h000000, 32, 32, "R3");
        idle(6, "R7");
        // R4: start-aligned
        restart(2'b01);
        send_frame(24'hA5A5A5, 24'h5A5A5A, 32, 32, "R4");
        send_frame(24'h000001, 24'h800000, 32, 32, "R4");
        idle(6, "R7");
        // R6: fill bits forced high must not leak
        fill_mode = 1;
        send_frame(24'h000000, 24'h000000, 32, 32, "R6");
        send_frame(24'h0F0F0F, 24'h00FF00, 32, 32, "R6");
        fill_mode = 0;
        // R5: end-aligned
        restart(2'b10);
        send_frame(24'hC0FFEE, 24'hBEEF01, 32, 32, "R5");
        send_frame(24'h13579B, 24'h2468AC, 32, 32, "R5");
        fill_mode = 1;
        send_frame(24'h000000, 24'h000001, 32, 32, "R6");
        fill_mode = 0;
        // R8: short right half then recovery
        send_frame(24'h111111, 24'h222222, 32, 31, "R8");
        send_frame(24'h333333, 24'h444444, 32, 32, "R8");
        // R9: short left half, full right gives no strobe
        send_frame(24'h555555, 24'h666666, 31, 32, "R9");
        send_frame(24'h777777, 24'h888888, 32, 32, "R9");
        idle(6, "R7");
        // R2: reserved code behaves as inter-IC sound
        restart(2'b11);
        send_frame(24'hDEAD01, 24'hFACE02, 32, 32, "R2");
        send_frame(24'h010203, 24'h040506, 32, 32, "R2");
        idle(6, "R7");
        @(negedge clk);
        compare();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule